// File: doc/BRIEF.md
# Configurable Macrocell Register

This block is one logic cell of a programmable-logic fabric. Five direct product terms, plus a partial sum borrowed from a neighbouring cell, are gathered by a masked OR and then passed through a polarity stage. The result either leaves the cell directly or is stored in a register that behaves as a D or a T flip-flop. Static configuration inputs choose the storage mode, the clock source, the set and reset sources, the power-up value and the source of the pin output enable.

The cell runs on one fabric clock `clk`. The three global clocks and the product-term clock are treated as data: they are sampled each cycle, and a rising edge of the selected source, after any polarity change, is what clocks the storage. The set and reset terms, like the global set/reset, act as levels that override clocked updates. `init` is the synchronous power-on initialise pulse. All outputs are registered and change on the `clk` edge that samples their inputs.

Each control role has its own direct term: `pterm[0]` is the clock term, `pterm[1]` the set term, `pterm[2]` the reset term and `pterm[3]` the enable term. When a role is configured to use its term, that term is removed from the data sum.

Top module: `mc_cell`

## Requirements
- R1: While `init` is high at a `clk` edge, the storage and `cell_out` take `cfg_preload` and `pin_oe` goes to 0.
- R2: With `cfg_mode` = 0 (bypass), `cell_out` after a `clk` edge equals the data sum of the inputs sampled at that edge.
- R3: The data sum is the OR of `pterm & cfg_sum_mask`, ORed with `share_in` when `cfg_share_en` is 1, then XORed with `cfg_invert`. Mode code 3 also means bypass.
- R4: A direct term that serves a role in use is left out of the sum. The roles in use are: the clock term when `cfg_clk_sel` = 3, the set term when `cfg_set_en` = 1, the reset term when `cfg_rst_en` = 1, and the enable term when `cfg_oe_sel` = 2.
- R5: With `cfg_mode` = 1 (D), the storage loads the sum at each clock event. A clock event is a `clk` edge at which the selected source is 1 and was 0 at the previous edge.
- R6: With `cfg_mode` = 2 (T), the storage inverts at a clock event when the sum is 1. It holds when the sum is 0, and it holds whenever there is no clock event.
- R7: `cfg_clk_sel` values 0 to 2 pick `glb_clk[sel]`, inverted when `cfg_clk_inv` = 1. Value 3 picks the clock term, which is never inverted.
- R8: An enabled set term forces the storage to 1 and an enabled reset term forces it to 0. Both act while their term is 1, override clock events, and reset wins when both are active.
- R9: While `glb_setrst` is 1 (and `init` is 0), the storage takes `cfg_preload`. This takes priority over the set term, the reset term and clock events.
- R10: `cfg_oe_sel` selects the output enable: 0 gives 0, 1 gives 1, 2 gives the enable term, and 3 gives `glb_oe[cfg_goe_idx]` XOR `cfg_goe_inv`.
- R11: When `cfg_oe_sel` = 3 and `cfg_goe_idx` >= NUM_GOE, `pin_oe` is 0 whatever `cfg_goe_inv` is.
- R12: `pin_out` always equals `cell_out`. In the D and T modes `cell_out` equals the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| init | input | 1 | Power-on initialise pulse, synchronous, active high |
| pterm | input | NUM_PT | Direct product terms |
| share_in | input | 1 | Partial sum borrowed from a neighbouring cell |
| glb_clk | input | NUM_GCLK | Global clocks, sampled |
| glb_setrst | input | 1 | Global set/reset to the preload value |
| glb_oe | input | NUM_GOE | Global output enables |
| cfg_mode | input | 2 | 0/3 bypass, 1 D, 2 T |
| cfg_sum_mask | input | NUM_PT | Terms admitted to the sum |
| cfg_share_en | input | 1 | Admit share_in to the sum |
| cfg_invert | input | 1 | Invert the sum |
| cfg_clk_sel | input | clog2(NUM_GCLK+1) | Clock source |
| cfg_clk_inv | input | 1 | Invert the selected global clock |
| cfg_set_en | input | 1 | Use the set term |
| cfg_rst_en | input | 1 | Use the reset term |
| cfg_preload | input | 1 | Power-up and global set/reset value |
| cfg_oe_sel | input | 2 | Output-enable source |
| cfg_goe_idx | input | 2 | Global enable index |
| cfg_goe_inv | input | 1 | Invert the global enable |
| cell_out | output | 1 | Cell result to the routing fabric |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench builds two copies of the cell with the same stimulus: one with four global enables and one with two. The four-enable copy checks that every index reaches a real global enable. The two-enable copy brings indices 2 and 3 within reach, so the forced-low enable of R11 is exercised under both polarity settings. Both copies use five product terms and three global clocks, which makes the clock selector's fourth code the product-term clock.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MODE_COMB  = 2'd0,
    MODE_DFF   = 2'd1,
    MODE_TFF   = 2'd2,
    MODE_COMB2 = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OE_OFF    = 2'd0,
    OE_ON     = 2'd1,
    OE_TERM   = 2'd2,
    OE_GLOBAL = 2'd3
  } oe_src_e;

  // direct-term roles
  localparam int TERM_CLK = 0;
  localparam int TERM_SET = 1;
  localparam int TERM_RST = 2;
  localparam int TERM_OE  = 3;
  localparam int MAX_GOE  = 4;
endpackage

// File: rtl/mc_sum.sv
module mc_sum #(
  parameter int NUM_PT = 5
) (
  input  logic [NUM_PT-1:0] pterm,
  input  logic              share_in,
  input  logic [NUM_PT-1:0] sum_mask,
  input  logic              share_en,
  input  logic              invert,
  input  logic              use_clk,
  input  logic              use_set,
  input  logic              use_rst,
  input  logic              use_oe,
  output logic              sum
);
  import mc_pkg::*;

  logic [NUM_PT-1:0] ctrl_use;
  logic [NUM_PT-1:0] admitted;

  always_comb begin
    ctrl_use           = '0;
    ctrl_use[TERM_CLK] = use_clk;
    ctrl_use[TERM_SET] = use_set;
    ctrl_use[TERM_RST] = use_rst;
    ctrl_use[TERM_OE]  = use_oe;
  end

  // terms claimed by a control role leave the sum (R4)
  assign admitted = pterm & sum_mask & ~ctrl_use;
  assign sum      = ((|admitted) | (share_en & share_in)) ^ invert;
endmodule

// File: rtl/mc_clksel.sv
module mc_clksel #(
  parameter int NUM_GCLK = 3,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                init,
  input  logic [NUM_GCLK-1:0] glb_clk,
  input  logic                term_clk,
  input  logic [SEL_W-1:0]    sel,
  input  logic                inv,
  output logic                clk_event
);
  localparam int NSRC = 2 ** SEL_W;

  logic [NSRC-1:0] src_vec;
  logic            src;
  logic            src_prev;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      if (g < NUM_GCLK) begin : g_glb
        assign src_vec[g] = glb_clk[g] ^ inv;
      end else begin : g_term
        assign src_vec[g] = term_clk;
      end
    end
  endgenerate

  assign src = src_vec[sel];

  always_ff @(posedge clk) begin
    src_prev <= src;
  end

  assign clk_event = src & ~src_prev;

  // a rising edge cannot follow a rising edge directly (R5)
  assert_edge_spacing_R5: assert property (@(posedge clk) disable iff (init)
    clk_event |=> !clk_event);
endmodule

// File: rtl/mc_oesel.sv
module mc_oesel #(
  parameter int NUM_GOE = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               init,
  input  logic [1:0]         sel,
  input  logic               term_oe,
  input  logic [NUM_GOE-1:0] glb_oe,
  input  logic [IDX_W-1:0]   idx,
  input  logic               inv,
  output logic               oe_q
);
  import mc_pkg::*;

  localparam int NSLOT = 2 ** IDX_W;

  logic [NSLOT-1:0] slot;
  logic             oe_next;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      if (g < NUM_GOE) begin : g_real
        assign slot[g] = glb_oe[g] ^ inv;
      end else begin : g_absent
        assign slot[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    case (oe_src_e'(sel))
      OE_OFF:  oe_next = 1'b0;
      OE_ON:   oe_next = 1'b1;
      OE_TERM: oe_next = term_oe;
      default: oe_next = slot[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (init) oe_q <= 1'b0;
    else      oe_q <= oe_next;
  end

  assert_oe_off_R10: assert property (@(posedge clk) disable iff (init)
    (sel == 2'd0) |=> !oe_q);

  assert_oe_absent_R11: assert property (@(posedge clk) disable iff (init)
    (sel == 2'd3 && int'(idx) >= NUM_GOE) |=> !oe_q);
endmodule

// File: rtl/mc_reg.sv
module mc_reg (
  input  logic       clk,
  input  logic       init,
  input  logic       preload,
  input  logic       glb_setrst,
  input  logic       set_req,
  input  logic       rst_req,
  input  logic       clk_event,
  input  logic [1:0] mode,
  input  logic       d,
  output logic       q
);
  import mc_pkg::*;

  always_ff @(posedge clk) begin
    if (init)            q <= preload;
    else if (glb_setrst) q <= preload;
    else if (rst_req)    q <= 1'b0;
    else if (set_req)    q <= 1'b1;
    else if (clk_event) begin
      case (mode_e'(mode))
        MODE_DFF: q <= d;
        MODE_TFF: q <= q ^ d;
        default:  q <= q;
      endcase
    end
  end

  assert_reset_wins_R8: assert property (@(posedge clk) disable iff (init)
    (rst_req && !glb_setrst) |=> !q);

  assert_global_preload_R9: assert property (@(posedge clk) disable iff (init)
    glb_setrst |=> (q == $past(preload)));

  assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (init)
    (mode == 2'd2 && !clk_event && !glb_setrst && !set_req && !rst_req) |=> $stable(q));
endmodule

// File: rtl/mc_cell.sv
module mc_cell #(
  parameter int NUM_PT   = 5,
  parameter int NUM_GCLK = 3,
  parameter int NUM_GOE  = 4,
  localparam int CLK_SEL_W = $clog2(NUM_GCLK + 1),
  localparam int GOE_IDX_W = $clog2(mc_pkg::MAX_GOE)
) (
  input  logic                 clk,
  input  logic                 init,
  input  logic [NUM_PT-1:0]    pterm,
  input  logic                 share_in,
  input  logic [NUM_GCLK-1:0]  glb_clk,
  input  logic                 glb_setrst,
  input  logic [NUM_GOE-1:0]   glb_oe,
  input  logic [1:0]           cfg_mode,
  input  logic [NUM_PT-1:0]    cfg_sum_mask,
  input  logic                 cfg_share_en,
  input  logic                 cfg_invert,
  input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
  input  logic                 cfg_clk_inv,
  input  logic                 cfg_set_en,
  input  logic                 cfg_rst_en,
  input  logic                 cfg_preload,
  input  logic [1:0]           cfg_oe_sel,
  input  logic [GOE_IDX_W-1:0] cfg_goe_idx,
  input  logic                 cfg_goe_inv,
  output logic                 cell_out,
  output logic                 pin_out,
  output logic                 pin_oe
);
  import mc_pkg::*;

  // NUM_GOE is meant to be 2 or 4; NUM_PT must cover the four role terms
  localparam logic [CLK_SEL_W-1:0] SEL_TERM = CLK_SEL_W'(NUM_GCLK);

  logic use_clk_term;
  logic use_oe_term;
  logic sum_w;
  logic clk_event;
  logic store_q;
  logic comb_q;
  logic is_comb;

  assign use_clk_term = (cfg_clk_sel == SEL_TERM);
  assign use_oe_term  = (cfg_oe_sel == 2'd2);
  assign is_comb      = (cfg_mode == 2'd0) || (cfg_mode == 2'd3);

  mc_sum #(.NUM_PT(NUM_PT)) u_sum (
    .pterm    (pterm),
    .share_in (share_in),
    .sum_mask (cfg_sum_mask),
    .share_en (cfg_share_en),
    .invert   (cfg_invert),
    .use_clk  (use_clk_term),
    .use_set  (cfg_set_en),
    .use_rst  (cfg_rst_en),
    .use_oe   (use_oe_term),
    .sum      (sum_w)
  );

  mc_clksel #(.NUM_GCLK(NUM_GCLK), .SEL_W(CLK_SEL_W)) u_clksel (
    .clk       (clk),
    .init      (init),
    .glb_clk   (glb_clk),
    .term_clk  (pterm[TERM_CLK]),
    .sel       (cfg_clk_sel),
    .inv       (cfg_clk_inv),
    .clk_event (clk_event)
  );

  mc_reg u_reg (
    .clk        (clk),
    .init       (init),
    .preload    (cfg_preload),
    .glb_setrst (glb_setrst),
    .set_req    (cfg_set_en & pterm[TERM_SET]),
    .rst_req    (cfg_rst_en & pterm[TERM_RST]),
    .clk_event  (clk_event),
    .mode       (cfg_mode),
    .d          (sum_w),
    .q          (store_q)
  );

  mc_oesel #(.NUM_GOE(NUM_GOE), .IDX_W(GOE_IDX_W)) u_oesel (
    .clk     (clk),
    .init    (init),
    .sel     (cfg_oe_sel),
    .term_oe (pterm[TERM_OE]),
    .glb_oe  (glb_oe),
    .idx     (cfg_goe_idx),
    .inv     (cfg_goe_inv),
    .oe_q    (pin_oe)
  );

  // registered bypass path
  always_ff @(posedge clk) begin
    if (init) comb_q <= cfg_preload;
    else      comb_q <= sum_w;
  end

  assign cell_out = is_comb ? comb_q : store_q;
  assign pin_out  = cell_out;

  assert_bypass_follows_R2: assert property (@(posedge clk) disable iff (init)
    is_comb |=> (!is_comb || cell_out == $past(sum_w)));
endmodule

// File: tb/mc_cell_tb.sv
module mc_cell_tb;
  logic       clk = 1'b0;
  logic       init;
  logic [4:0] pterm;
  logic       share_in;
  logic [2:0] glb_clk;
  logic       glb_setrst;
  logic [3:0] glb_oe;
  logic [1:0] cfg_mode;
  logic [4:0] cfg_sum_mask;
  logic       cfg_share_en, cfg_invert;
  logic [1:0] cfg_clk_sel;
  logic       cfg_clk_inv, cfg_set_en, cfg_rst_en, cfg_preload;
  logic [1:0] cfg_oe_sel, cfg_goe_idx;
  logic       cfg_goe_inv;
  logic       co1, po1, oe1, co2, po2, oe2;

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R1";
  bit    allow_gsr = 1'b0;

  always #5 clk = ~clk;

  mc_cell #(.NUM_PT(5), .NUM_GCLK(3), .NUM_GOE(4)) u_dut (
    .clk(clk), .init(init), .pterm(pterm), .share_in(share_in), .glb_clk(glb_clk),
    .glb_setrst(glb_setrst), .glb_oe(glb_oe), .cfg_mode(cfg_mode),
    .cfg_sum_mask(cfg_sum_mask), .cfg_share_en(cfg_share_en), .cfg_invert(cfg_invert),
    .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv), .cfg_set_en(cfg_set_en),
    .cfg_rst_en(cfg_rst_en), .cfg_preload(cfg_preload), .cfg_oe_sel(cfg_oe_sel),
    .cfg_goe_idx(cfg_goe_idx), .cfg_goe_inv(cfg_goe_inv),
    .cell_out(co1), .pin_out(po1), .pin_oe(oe1));

  mc_cell #(.NUM_PT(5), .NUM_GCLK(3), .NUM_GOE(2)) u_dut2 (
    .clk(clk), .init(init), .pterm(pterm), .share_in(share_in), .glb_clk(glb_clk),
    .glb_setrst(glb_setrst), .glb_oe(glb_oe[1:0]), .cfg_mode(cfg_mode),
    .cfg_sum_mask(cfg_sum_mask), .cfg_share_en(cfg_share_en), .cfg_invert(cfg_invert),
    .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv), .cfg_set_en(cfg_set_en),
    .cfg_rst_en(cfg_rst_en), .cfg_preload(cfg_preload), .cfg_oe_sel(cfg_oe_sel),
    .cfg_goe_idx(cfg_goe_idx), .cfg_goe_inv(cfg_goe_inv),
    .cell_out(co2), .pin_out(po2), .pin_oe(oe2));

  // behavioural reference, evaluated from the requirements at every edge
  logic m_q[2], m_out[2], m_oe[2];
  logic m_prev;

  always @(posedge clk) begin : model
    logic [4:0] msk;
    logic s, src, ev, nq, noe;
    int ngoe;
    msk = cfg_sum_mask;
    if (cfg_clk_sel == 2'd3) msk[0] = 1'b0;
    if (cfg_set_en)          msk[1] = 1'b0;
    if (cfg_rst_en)          msk[2] = 1'b0;
    if (cfg_oe_sel == 2'd2)  msk[3] = 1'b0;
    s = ((pterm & msk) != 5'd0) || (cfg_share_en && share_in);
    s = s ^ cfg_invert;
    src = (cfg_clk_sel == 2'd3) ? pterm[0] : (glb_clk[cfg_clk_sel] ^ cfg_clk_inv);
    ev = src && !m_prev;
    m_prev <= src;
    for (int d = 0; d < 2; d++) begin
      ngoe = (d == 0) ? 4 : 2;
      if (init) begin
        m_q[d] <= cfg_preload; m_out[d] <= cfg_preload; m_oe[d] <= 1'b0;
      end else begin
        nq = m_q[d];
        if (glb_setrst)                 nq = cfg_preload;
        else if (cfg_rst_en && pterm[2]) nq = 1'b0;
        else if (cfg_set_en && pterm[1]) nq = 1'b1;
        else if (ev && cfg_mode == 2'd1) nq = s;
        else if (ev && cfg_mode == 2'd2) nq = nq ^ s;
        m_q[d] <= nq;
        m_out[d] <= (cfg_mode == 2'd1 || cfg_mode == 2'd2) ? nq : s;
        case (cfg_oe_sel)
          2'd0: noe = 1'b0;
          2'd1: noe = 1'b1;
          2'd2: noe = pterm[3];
          default: noe = (int'(cfg_goe_idx) < ngoe) ? (glb_oe[cfg_goe_idx] ^ cfg_goe_inv) : 1'b0;
        endcase
        m_oe[d] <= noe;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(co1, m_out[0], tag, "cell_out dut4");
    chk(co2, m_out[1], tag, "cell_out dut2");
    chk(po1, m_out[0], "R12", "pin_out dut4");
    chk(po2, m_out[1], "R12", "pin_out dut2");
    chk(oe1, m_oe[0], tag, "pin_oe dut4");
    chk(oe2, m_oe[1], tag, "pin_oe dut2");
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      pterm      = 5'($urandom);
      share_in   = 1'($urandom);
      glb_clk    = 3'($urandom);
      glb_oe     = 4'($urandom);
      glb_setrst = allow_gsr && ($urandom % 5 == 0);
    end
  endtask

  task automatic base_cfg();
    cfg_mode = 2'd1; cfg_sum_mask = 5'b11111; cfg_share_en = 1'b0; cfg_invert = 1'b0;
    cfg_clk_sel = 2'd0; cfg_clk_inv = 1'b0; cfg_set_en = 1'b0; cfg_rst_en = 1'b0;
    cfg_oe_sel = 2'd1; cfg_goe_idx = 2'd0; cfg_goe_inv = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    init = 1'b1; pterm = '0; share_in = 1'b0; glb_clk = '0; glb_setrst = 1'b0; glb_oe = '0;
    cfg_preload = 1'b1;
    base_cfg();
    // R1: initialise to 1 then to 0, then run
    tag = "R1";
    repeat (2) @(negedge clk);
    compare_all();
    chk(co1, 1'b1, "R1", "preload 1");
    chk(oe1, 1'b0, "R1", "oe after init");
    cfg_preload = 1'b0;
    @(negedge clk);
    chk(co1, 1'b0, "R1", "preload 0");
    init = 1'b0;
    step(10);
    // R2: bypass with assorted sums
    tag = "R2";
    for (int k = 0; k < 6; k++) begin
      cfg_mode = 2'd0; cfg_sum_mask = 5'($urandom); cfg_share_en = 1'($urandom);
      step(15);
    end
    // R3: second bypass code, inversion, share
    tag = "R3";
    cfg_mode = 2'd3; cfg_sum_mask = 5'b00000; cfg_share_en = 1'b0; cfg_invert = 1'b1;
    step(6);
    chk(co1, 1'b1, "R3", "empty sum inverted");
    cfg_share_en = 1'b1; step(15);
    cfg_sum_mask = 5'b10000; cfg_invert = 1'b0; step(15);
    // R4: control roles steal their terms
    tag = "R4";
    base_cfg(); cfg_mode = 2'd0; cfg_clk_sel = 2'd3; cfg_set_en = 1'b1;
    cfg_rst_en = 1'b1; cfg_oe_sel = 2'd2;
    step(30);
    // R5: D register on each global clock
    tag = "R5";
    base_cfg();
    for (int c = 0; c < 3; c++) begin cfg_clk_sel = 2'(c); step(20); end
    // R7: inverted globals and the term clock
    tag = "R7";
    cfg_clk_inv = 1'b1;
    for (int c = 0; c < 4; c++) begin cfg_clk_sel = 2'(c); step(20); end
    // R6: toggle register
    tag = "R6";
    base_cfg(); cfg_mode = 2'd2;
    for (int c = 0; c < 4; c++) begin
      cfg_clk_sel = 2'(c); cfg_sum_mask = 5'($urandom); cfg_invert = 1'($urandom);
      step(25);
    end
    // R8: set/reset terms, alone and together
    tag = "R8";
    base_cfg();
    for (int c = 0; c < 6; c++) begin
      cfg_mode = (c % 2 == 0) ? 2'd1 : 2'd2;
      cfg_set_en = (c != 1); cfg_rst_en = (c != 2);
      step(25);
    end
    // R9: global set/reset to either preload
    tag = "R9";
    allow_gsr = 1'b1;
    for (int c = 0; c < 4; c++) begin
      cfg_preload = c[0]; cfg_mode = c[1] ? 2'd2 : 2'd1;
      cfg_set_en = 1'b1; cfg_rst_en = 1'b1;
      step(30);
    end
    allow_gsr = 1'b0; glb_setrst = 1'b0;
    // R10: every enable source
    tag = "R10";
    base_cfg();
    for (int c = 0; c < 3; c++) begin cfg_oe_sel = 2'(c); step(8); end
    cfg_oe_sel = 2'd3;
    for (int c = 0; c < 4; c++) begin
      cfg_goe_idx = 2'(c % 2); cfg_goe_inv = c[1]; step(12);
    end
    // R11: absent global enable on the two-enable copy
    tag = "R11";
    for (int c = 0; c < 4; c++) begin
      cfg_goe_idx = 2'(2 + c % 2); cfg_goe_inv = c[1]; step(12);
      chk(oe2, 1'b0, "R11", "absent enable");
    end
    // R12: mixed random configuration
    tag = "R12";
    for (int k = 0; k < 20; k++) begin
      cfg_mode = 2'($urandom); cfg_sum_mask = 5'($urandom); cfg_share_en = 1'($urandom);
      cfg_invert = 1'($urandom); cfg_clk_sel = 2'($urandom); cfg_clk_inv = 1'($urandom);
      cfg_set_en = 1'($urandom); cfg_rst_en = 1'($urandom); cfg_oe_sel = 2'($urandom);
      cfg_goe_idx = 2'($urandom); cfg_goe_inv = 1'($urandom);
      step(20);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule